// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries out the memory side of entering an interrupt or an MMU configuration exception on a processor that has two supervisor stacks, a master stack and an interrupt stack. It takes a request that carries the following:

- whether the source returned a programmed vector, and the vector number itself;
- the address of the next instruction;
- the status register;
- both stack pointers and the vector base.

It then writes an exception frame, one 16-bit word at a time, through a simple write port. When the status register's master bit is set at entry, it writes a second, throwaway frame on the interrupt stack.

After the frames it reads the handler address from the vector table through the same port. It then presents the following as one registered result, marked by a one-cycle completion pulse:

- the new program counter;
- the exit status register;
- both updated stack pointers.

Each memory access waits for the port's ready signal, so a slow memory stretches the sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: The vector number is `req_vector` when `req_vec_ok`=1, 15 when an interrupt arrives with `req_vec_ok`=0, and 56 when `req_mmu`=1. The handler address is read as two words: the high half at `vbr` + 4·vector, then the low half at 2 bytes above that.
- R2: A frame is four writes, each to the selected stack pointer pre-decremented by 2. The writes go in this order: format word at SP−2, PC[15:0] at SP−4, PC[31:16] at SP−6, status register at SP−8. The format word holds the format code in bits 15:12 and 4·vector in bits 11:0.
- R3: The first frame's format code is 9 when `req_copro`=1 on an interrupt, and 0 otherwise (including every MMU configuration request).
- R4: With status bit 12 (master) clear at entry, one frame goes on the interrupt stack. `new_isp` is then `cur_isp`−8 and `new_msp` equals `cur_msp`.
- R5: With status bit 12 set at entry, the first frame goes on the master stack. A format-1 frame follows on the interrupt stack, with the same PC and offset. Its status copy equals the first frame's copy with bit 13 (supervisor) forced to 1. Both stack pointers end 8 lower.
- R6: At completion `new_sr` is the entry status with bit 13 set and bit 12 cleared, and all other bits unchanged. `new_pc` is the fetched handler address.
- R7: `busy` is high from the cycle after acceptance until the last read is acknowledged. `done` pulses for exactly one cycle after that, with `busy` low. The result outputs change only at that point.
- R8: A request presented while `busy` is high has no effect on the memory accesses or on the results.
- R9: `mem_wr` and `mem_rd` are never both high. While `mem_ready` is low, the strobe, address and write data hold their values.
- R10: A request presented in the cycle `done` is high is accepted, and its first write appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry request, taken when idle |
| req_mmu | input | 1 | 1 = MMU configuration exception, 0 = interrupt |
| req_vec_ok | input | 1 | Source returned a programmed vector |
| req_vector | input | 8 | Vector number from the source |
| req_copro | input | 1 | Interrupt taken during a coprocessor instruction |
| req_pc | input | 32 | Address of the next instruction |
| req_sr | input | 16 | Status register at entry |
| cur_isp | input | 32 | Interrupt stack pointer |
| cur_msp | input | 32 | Master stack pointer |
| vbr | input | 32 | Vector table base |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access acknowledged this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Exit status register |
| new_isp | output | 32 | Updated interrupt stack pointer |
| new_msp | output | 32 | Updated master stack pointer |

## Verification
Completion and acceptance can fall in the same cycle: `done` pulses while the sequencer is already idle, so a second request held in that cycle must start its first write on the very next cycle. The bench waits for `done` and drives a request in exactly that cycle. It then judges the write addresses, the write data and `busy` against a queue-based model that assumes no idle gap. A stall on the final read is provoked as well, by random ready patterns, because there the last acknowledgement, the result update and the completion pulse all depend on one edge.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_PUSH  = 2'd1,
      SQ_FETCH = 2'd2
   } sq_state_t;

   localparam logic [3:0] FMT_PLAIN = 4'h0;
   localparam logic [3:0] FMT_THROW = 4'h1;
   localparam logic [3:0] FMT_COPRO = 4'h9;
   localparam int unsigned OFFSET_W = 12;
   localparam int unsigned FMT_W    = 4;
endpackage

// File: rtl/irq_vec_resolve.sv
`timescale 1ns/1ps
module irq_vec_resolve
   import irq_entry_pkg::*;
#(
   parameter int unsigned VW         = 8,
   parameter int unsigned UNINIT_VEC = 15,
   parameter int unsigned CFG_VEC    = 56
) (
   input  logic                mmu,
   input  logic                vec_ok,
   input  logic [VW-1:0]       vec_in,
   input  logic                copro,
   output logic [OFFSET_W-1:0] offset,
   output logic [FMT_W-1:0]    fmt
);
   if (VW + 2 > OFFSET_W) begin : g_bad_vw
      $error("vector width does not fit the offset field");
   end
   if (UNINIT_VEC >= (1 << VW) || CFG_VEC >= (1 << VW)) begin : g_bad_fixed
      $error("fixed vector numbers exceed vector width");
   end

   logic [VW-1:0] vec_sel;

   always_comb begin
      if (mmu)         vec_sel = VW'(CFG_VEC);
      else if (vec_ok) vec_sel = vec_in;
      else             vec_sel = VW'(UNINIT_VEC);
      offset = OFFSET_W'(vec_sel) << 2;
      fmt    = (!mmu && copro) ? FMT_COPRO : FMT_PLAIN;
   end
endmodule

// File: rtl/irq_frame_word.sv
`timescale 1ns/1ps
module irq_frame_word
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 16,
   parameter int unsigned SR_S_BIT = 13,
   localparam int unsigned PW      = AW / DW,
   localparam int unsigned FW      = PW + 2,
   localparam int unsigned KW      = $clog2(FW)
) (
   input  logic [FMT_W-1:0]    fmt,
   input  logic [OFFSET_W-1:0] offset,
   input  logic [AW-1:0]       pc,
   input  logic [DW-1:0]       sr,
   input  logic                throwaway,
   input  logic [KW-1:0]       idx,
   output logic [DW-1:0]       word
);
   logic [DW-1:0] words [FW];
   logic [DW-1:0] sr_copy;

   always_comb begin
      sr_copy = sr;
      if (throwaway) sr_copy[SR_S_BIT] = 1'b1;
   end

   assign words[0]    = {(throwaway ? FMT_THROW : fmt), offset};
   assign words[FW-1] = sr_copy;

   for (genvar i = 0; i < PW; i++) begin : g_pc_word
      assign words[i+1] = pc[i*DW +: DW];
   end

   assign word = words[idx];
endmodule

// File: rtl/irq_entry_core.sv
`timescale 1ns/1ps
module irq_entry_core
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW       = 32,
   parameter int unsigned DW       = 16,
   parameter int unsigned SR_S_BIT = 13,
   parameter int unsigned SR_M_BIT = 12,
   localparam int unsigned PW      = AW / DW,
   localparam int unsigned FW      = PW + 2,
   localparam int unsigned KW      = $clog2(FW),
   localparam int unsigned BYTES   = DW / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [FMT_W-1:0]    req_fmt,
   input  logic [OFFSET_W-1:0] req_offset,
   input  logic [AW-1:0]       req_pc,
   input  logic [DW-1:0]       req_sr,
   input  logic [AW-1:0]       req_isp,
   input  logic [AW-1:0]       req_msp,
   input  logic [AW-1:0]       req_fetch,
   output logic                mem_wr,
   output logic                mem_rd,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic [DW-1:0]       mem_rdata,
   input  logic                mem_ready,
   output logic                busy,
   output logic                done,
   output logic [AW-1:0]       new_pc,
   output logic [DW-1:0]       new_sr,
   output logic [AW-1:0]       new_isp,
   output logic [AW-1:0]       new_msp
);
   sq_state_t           state;
   logic [KW-1:0]       k;
   logic                two_frames, second;
   logic [AW-1:0]       sp_work, lat_isp, lat_msp, lat_fetch, lat_pc, pc_acc, pc_next;
   logic [DW-1:0]       lat_sr, exit_sr, frame_data;
   logic [FMT_W-1:0]    lat_fmt;
   logic [OFFSET_W-1:0] lat_off;
   logic                last_word, last_read;

   assign last_word = (k == KW'(FW - 1));
   assign last_read = (k == KW'(PW - 1));

   irq_frame_word #(.AW(AW), .DW(DW), .SR_S_BIT(SR_S_BIT)) u_word (
      .fmt(lat_fmt), .offset(lat_off), .pc(lat_pc), .sr(lat_sr),
      .throwaway(second), .idx(k), .word(frame_data)
   );

   always_comb begin
      exit_sr = lat_sr;
      exit_sr[SR_S_BIT] = 1'b1;
      exit_sr[SR_M_BIT] = 1'b0;
      pc_next = pc_acc;
      pc_next[(PW - 1 - int'(k)) * DW +: DW] = mem_rdata;
   end

   assign mem_wr    = (state == SQ_PUSH);
   assign mem_rd    = (state == SQ_FETCH);
   assign busy      = (state != SQ_IDLE);
   assign mem_wdata = mem_wr ? frame_data : '0;
   assign mem_addr  = mem_wr ? (sp_work - AW'(BYTES))
                    : mem_rd ? (lat_fetch + AW'(k) * AW'(BYTES)) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;   k <= '0;       two_frames <= 1'b0; second <= 1'b0;
         sp_work <= '0;      lat_isp <= '0; lat_msp <= '0;      lat_fetch <= '0;
         lat_pc <= '0;       lat_sr <= '0;  lat_fmt <= '0;      lat_off <= '0;
         pc_acc <= '0;       done <= 1'b0;  new_pc <= '0;       new_sr <= '0;
         new_isp <= '0;      new_msp <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SQ_IDLE: if (req_valid) begin
               lat_fmt    <= req_fmt;    lat_off <= req_offset;
               lat_pc     <= req_pc;     lat_sr  <= req_sr;
               lat_isp    <= req_isp;    lat_msp <= req_msp;
               lat_fetch  <= req_fetch;
               two_frames <= req_sr[SR_M_BIT];
               second     <= 1'b0;
               sp_work    <= req_sr[SR_M_BIT] ? req_msp : req_isp;
               k          <= '0;
               state      <= SQ_PUSH;
            end
            SQ_PUSH: if (mem_ready) begin
               sp_work <= sp_work - AW'(BYTES);
               if (last_word) begin
                  k <= '0;
                  if (two_frames && !second) begin
                     lat_msp <= sp_work - AW'(BYTES);
                     second  <= 1'b1;
                     sp_work <= lat_isp;
                  end else begin
                     lat_isp <= sp_work - AW'(BYTES);
                     state   <= SQ_FETCH;
                  end
               end else begin
                  k <= k + 1'b1;
               end
            end
            SQ_FETCH: if (mem_ready) begin
               pc_acc <= pc_next;
               if (last_read) begin
                  state   <= SQ_IDLE;
                  done    <= 1'b1;
                  new_pc  <= pc_next;
                  new_sr  <= exit_sr;
                  new_isp <= lat_isp;
                  new_msp <= lat_msp;
               end else begin
                  k <= k + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_wr && mem_rd));
   assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
   assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_exit_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (new_sr[SR_S_BIT] && !new_sr[SR_M_BIT]));
   assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(new_pc) && $stable(new_isp) && $stable(new_msp)));
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned DW         = 16,
   parameter int unsigned VW         = 8,
   parameter int unsigned SR_S_BIT   = 13,
   parameter int unsigned SR_M_BIT   = 12,
   parameter int unsigned UNINIT_VEC = 15,
   parameter int unsigned CFG_VEC    = 56
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_mmu,
   input  logic          req_vec_ok,
   input  logic [VW-1:0] req_vector,
   input  logic          req_copro,
   input  logic [AW-1:0] req_pc,
   input  logic [DW-1:0] req_sr,
   input  logic [AW-1:0] cur_isp,
   input  logic [AW-1:0] cur_msp,
   input  logic [AW-1:0] vbr,
   output logic          mem_wr,
   output logic          mem_rd,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ready,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] new_pc,
   output logic [DW-1:0] new_sr,
   output logic [AW-1:0] new_isp,
   output logic [AW-1:0] new_msp
);
   if (DW != FMT_W + OFFSET_W) begin : g_bad_dw
      $error("frame word width must equal format plus offset width");
   end
   if (AW % DW != 0 || AW < 2 * DW) begin : g_bad_aw
      $error("address width must be a multiple of at least two words");
   end
   if (SR_S_BIT >= DW || SR_M_BIT >= DW || SR_S_BIT == SR_M_BIT) begin : g_bad_sr
      $error("status bit positions invalid");
   end

   logic [OFFSET_W-1:0] offset;
   logic [FMT_W-1:0]    fmt;

   irq_vec_resolve #(.VW(VW), .UNINIT_VEC(UNINIT_VEC), .CFG_VEC(CFG_VEC)) u_vec (
      .mmu(req_mmu), .vec_ok(req_vec_ok), .vec_in(req_vector), .copro(req_copro),
      .offset(offset), .fmt(fmt)
   );

   irq_entry_core #(.AW(AW), .DW(DW), .SR_S_BIT(SR_S_BIT), .SR_M_BIT(SR_M_BIT)) u_core (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_fmt(fmt), .req_offset(offset), .req_pc(req_pc), .req_sr(req_sr),
      .req_isp(cur_isp), .req_msp(cur_msp), .req_fetch(vbr + AW'(offset)),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done), .new_pc(new_pc), .new_sr(new_sr),
      .new_isp(new_isp), .new_msp(new_msp)
   );
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
   typedef struct {
      bit          wr;
      logic [31:0] addr;
      logic [15:0] data;
      string       tag;
   } op_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_mmu = 1'b0, req_vec_ok = 1'b0, req_copro = 1'b0;
   logic [7:0]  req_vector = '0;
   logic [31:0] req_pc = '0, cur_isp = '0, cur_msp = '0, vbr = '0;
   logic [15:0] req_sr = '0;
   logic        mem_wr, mem_rd, mem_ready = 1'b1, busy, done;
   logic [31:0] mem_addr, new_pc, new_isp, new_msp;
   logic [15:0] mem_wdata, mem_rdata, new_sr;

   int  n_vec = 0, n_bad = 0;
   bit  checking = 1'b0, stall_mode = 1'b0, finished = 1'b0;
   string cur_tag = "R4";

   op_t         q[$];
   bit          done_exp = 1'b0;
   logic [31:0] e_pc = '0, e_isp = '0, e_msp = '0, p_pc, p_isp, p_msp;
   logic [15:0] e_sr = '0, p_sr;

   always #2.5 clk = ~clk;

   irq_entry_seq dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mmu(req_mmu),
      .req_vec_ok(req_vec_ok), .req_vector(req_vector), .req_copro(req_copro),
      .req_pc(req_pc), .req_sr(req_sr), .cur_isp(cur_isp), .cur_msp(cur_msp), .vbr(vbr),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
      .new_pc(new_pc), .new_sr(new_sr), .new_isp(new_isp), .new_msp(new_msp)
   );

   function automatic logic [15:0] table_word(logic [31:0] a);
      return a[15:0] ^ 16'hA5C3 ^ {a[23:16], a[31:24]};
   endfunction

   assign mem_rdata = mem_rd ? table_word(mem_addr) : 16'h0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic push_frame(ref logic [31:0] sp, input logic [3:0] fmt,
                             input logic [11:0] off, input logic [31:0] pc,
                             input logic [15:0] sr, input string tag);
      op_t o;
      o.wr = 1'b1; o.tag = tag;
      sp -= 2; o.addr = sp; o.data = {fmt, off};  q.push_back(o);
      sp -= 2; o.addr = sp; o.data = pc[15:0];    q.push_back(o);
      sp -= 2; o.addr = sp; o.data = pc[31:16];   q.push_back(o);
      sp -= 2; o.addr = sp; o.data = sr;          q.push_back(o);
   endtask

   // Reference model: builds the expected access list at acceptance, consumes it on ready.
   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete(); done_exp <= 1'b0;
         e_pc <= '0; e_sr <= '0; e_isp <= '0; e_msp <= '0;
      end else begin
         done_exp <= 1'b0;
         if (q.size() > 0) begin
            if (mem_ready) begin
               void'(q.pop_front());
               if (q.size() == 0) begin
                  done_exp <= 1'b1;
                  e_pc <= p_pc; e_sr <= p_sr; e_isp <= p_isp; e_msp <= p_msp;
               end
            end
         end else if (req_valid) begin
            int unsigned vec;
            logic [11:0] off;
            logic [3:0]  fmt;
            logic [31:0] sp, base;
            op_t         o;
            vec = req_mmu ? 56 : (req_vec_ok ? int'(req_vector) : 15);
            off = 12'(vec * 4);
            fmt = (!req_mmu && req_copro) ? 4'h9 : 4'h0;
            if (req_sr[12]) begin
               sp = cur_msp;
               push_frame(sp, fmt, off, req_pc, req_sr, cur_tag);
               p_msp = sp;
               sp = cur_isp;
               push_frame(sp, 4'h1, off, req_pc, req_sr | 16'h2000, "R5");
               p_isp = sp;
            end else begin
               sp = cur_isp;
               push_frame(sp, fmt, off, req_pc, req_sr, cur_tag);
               p_isp = sp; p_msp = cur_msp;
            end
            base = vbr + 32'(off);
            o.wr = 1'b0; o.data = '0; o.tag = "R1";
            o.addr = base;      q.push_back(o);
            o.addr = base + 2;  q.push_back(o);
            p_pc = {table_word(base), table_word(base + 2)};
            p_sr = (req_sr | 16'h2000) & ~16'h1000;
         end
      end
   end

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (checking && !finished) begin
         chk("R7 busy", 32'(busy), 32'(q.size() > 0));
         chk("R7 done", 32'(done), 32'(done_exp));
         if (q.size() > 0) begin
            chk({"R9 wr strobe ", q[0].tag}, 32'(mem_wr), 32'(q[0].wr));
            chk({"R9 rd strobe ", q[0].tag}, 32'(mem_rd), 32'(!q[0].wr));
            chk({q[0].wr ? "R2 addr " : "R1 addr ", q[0].tag}, mem_addr, q[0].addr);
            if (q[0].wr) chk({"R2 data ", q[0].tag}, 32'(mem_wdata), 32'(q[0].data));
         end else begin
            chk("R8 idle strobes", 32'({mem_wr, mem_rd}), 32'd0);
         end
         chk("R6 new_pc", new_pc, e_pc);
         chk("R6 new_sr", 32'(new_sr), 32'(e_sr));
         chk("R4 new_isp", new_isp, e_isp);
         chk("R5 new_msp", new_msp, e_msp);
      end
      mem_ready = stall_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   task automatic finish_run();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy || done);
   endtask

   task automatic send(bit mmu, bit vok, logic [7:0] vec, bit cop, logic [31:0] pc,
                       logic [15:0] sr, logic [31:0] isp, logic [31:0] msp,
                       logic [31:0] base, string tag);
      cur_tag = tag;
      req_mmu = mmu; req_vec_ok = vok; req_vector = vec; req_copro = cop;
      req_pc = pc; req_sr = sr; cur_isp = isp; cur_msp = msp; vbr = base;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 reset busy", 32'(busy), 32'd0);
      chk("R7 reset done", 32'(done), 32'd0);
      chk("R6 reset pc", new_pc, 32'd0);
      checking = 1'b1;

      // R4: single frame on the interrupt stack, programmed vector (R1)
      send(0, 1, 8'd64, 0, 32'h0001_2344, 16'h2700, 32'h0000_8000, 32'h0000_9000, 32'h0000_0400, "R4");
      wait_idle();
      // R1: no programmed vector -> 15
      send(0, 0, 8'd99, 0, 32'hDEAD_BEE0, 16'h2004, 32'h0000_7F00, 32'h0000_6000, 32'h0001_0000, "R1");
      wait_idle();
      // R3: coprocessor interrupt -> format 9
      send(0, 1, 8'd200, 1, 32'h0040_0010, 16'h0015, 32'h0000_5000, 32'h0000_A000, 32'h0000_0000, "R3");
      wait_idle();
      // R5: master bit set, two frames
      send(0, 1, 8'd70, 0, 32'h1234_5678, 16'h1704, 32'h0000_4000, 32'h0000_C000, 32'h0002_0000, "R5");
      wait_idle();
      // R1: MMU configuration request with master bit set, copro flag ignored (R3)
      send(1, 1, 8'd3, 1, 32'h00FF_0002, 16'h3000, 32'h0000_3000, 32'h0000_D000, 32'h0000_0800, "R1");
      wait_idle();
      // R9: random stalls on every access
      stall_mode = 1'b1;
      for (int i = 0; i < 6; i++) begin
         send(i[0], i[1], 8'(64 + i * 13), i[2], 32'h0100_0000 + 32'(i * 6),
              16'h2000 | (i[0] ? 16'h1000 : 16'h0) | 16'(i), 32'h0000_8000 - 32'(i * 64),
              32'h0000_F000 - 32'(i * 32), 32'h0003_0000, "R9");
         wait_idle();
      end
      // R8: requests while busy are ignored
      send(0, 1, 8'd80, 0, 32'h0200_0000, 16'h1700, 32'h0000_7000, 32'h0000_E000, 32'h0000_1000, "R8");
      repeat (5) begin
         send(1, 0, 8'd1, 1, 32'hFFFF_FFFE, 16'h0000, 32'h0000_0100, 32'h0000_0200, 32'h0000_0300, "R8");
      end
      wait_idle();
      // R10: request presented in the done cycle
      stall_mode = 1'b0;
      send(0, 1, 8'd90, 0, 32'h0300_0000, 16'h2000, 32'h0000_6800, 32'h0000_E800, 32'h0000_2000, "R10");
      do @(negedge clk); while (!done);
      send(0, 1, 8'd91, 1, 32'h0300_0100, 16'h1000, 32'h0000_6000, 32'h0000_E000, 32'h0000_2000, "R10");
      stall_mode = 1'b1;
      do @(negedge clk); while (!done);
      send(0, 0, 8'd0, 0, 32'h0300_0200, 16'h2500, 32'h0000_5800, 32'h0000_D800, 32'h0000_2400, "R10");
      wait_idle();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule